// File: doc/BRIEF.md
# Shadowed RAM Store/Recall Controller

This block pairs a small working RAM with a nonvolatile shadow copy of the same size. The host reads and writes the working RAM through a chip-select port with active-low controls and one enable per byte lane. On request, the controller moves the whole contents in bulk. A STORE copies the working RAM into the shadow. A RECALL copies the shadow back into the working RAM. Either transfer moves one word per clock over the full depth.

A STORE has three possible triggers. The first is the falling edge of a hardware request line, which acts only after a fixed delay. The second is a single-cycle software strobe. The third is the rising edge of a power-fail indication, which acts only while automatic store is enabled. Hardware and power-fail stores are skipped when nothing has been written since the last transfer. A software store always runs. A RECALL runs by itself after reset and can also be requested by a strobe.

While either transfer runs, the active-low busy output is driven low and all host accesses are refused. After a hardware or software store, the busy output is driven high for a short while before it is released.

Top module: `shadow_ram_ctrl`

## Requirements
- R1: A host read is sampled at a rising edge when `cs_n`=0, `oe_n`=0, `we_n`=1, `hw_req_n`=1 and no transfer runs. The addressed word appears on `rdata` after that edge. A host write is sampled at a rising edge when `cs_n`=0, `we_n`=0, `hw_req_n`=1 and no transfer runs. After reset `dq_oe` is 0.
- R2: Lane i covers data bits [8i+7:8i] and is enabled when `lane_n[i]`=0. A write updates only the enabled lanes. A read sets `dq_oe[i]` only for enabled lanes, and `rdata` bits of a disabled lane read 0.
- R3: While `busy_n`=0 a read leaves `dq_oe` at 0 and a write does not change the RAM.
- R4: An internal dirty flag is set by every accepted host write and cleared when a STORE or RECALL completes.
- R5: A hardware or power-fail STORE is skipped when the dirty flag is clear. A host write accepted at the same edge as the store decision counts as dirty.
- R6: A software STORE strobe (`sw_store`=1 for one cycle while idle) always starts a STORE, dirty or not.
- R7: A falling edge of `hw_req_n` sampled at edge E starts the conditional STORE at edge E+DELAY_CYC. `busy_n` therefore reads high for DELAY_CYC cycles after E.
- R8: During any STORE or RECALL, `busy_n`=0 and `busy_drv`=1 for exactly 2^ADDR_W cycles.
- R9: After a STORE that a software strobe or a hardware request started, `busy_n`=1 with `busy_drv`=1 for HOLD_CYC cycles, then `busy_drv`=0. After a RECALL, or after a STORE started only by power-fail, `busy_drv` drops at once.
- R10: A rising edge of `pwr_fail` while `auto_en`=1 requests a STORE. While `auto_en`=0 the edge is ignored.
- R11: A RECALL runs while reset is asserted and for 2^ADDR_W edges after release. A `sw_recall` strobe while idle also runs one. After a RECALL the working RAM equals the contents of the last STORE.
- R12: STORE triggers in the same cycle collapse into one STORE. When software contributes, the hold phase follows. An accepted power-fail STORE cancels a pending hardware request.
- R13: When `we_n` is sampled low while `oe_n`=0 and `cs_n`=0, enabled output lanes stay on for HZ_CYC cycles after the first such edge, then turn off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts a RECALL |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lane_n | input | LANES | Byte lane enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, disabled lanes zero |
| dq_oe | output | LANES | Per-lane output driver enable |
| hw_req_n | input | 1 | Hardware store request, falling edge |
| busy_n | output | 1 | Low while a transfer runs |
| busy_drv | output | 1 | High while the busy pin is actively driven |
| sw_store | input | 1 | Software store strobe |
| sw_recall | input | 1 | Software recall strobe |
| pwr_fail | input | 1 | Power-fail indication, rising edge |
| auto_en | input | 1 | Enables store on power-fail |

## Verification
Two things can land on the same clock edge: a host write and the maturing of a delayed hardware request. The bench leaves the RAM clean, drops `hw_req_n`, releases it, and times a write to land exactly DELAY_CYC edges later. It then judges that `busy_n` falls on the next sample, because the write counts as dirty. The same alignment is used after a power-fail STORE that runs through the hardware delay window. There the write hits the first idle edge, and the bench confirms that no second STORE follows, which shows the cancelled hardware request does not act.

// File: rtl/shram_pkg.sv
package shram_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_STORE  = 2'd1,
      SQ_RECALL = 2'd2,
      SQ_HOLD   = 2'd3
   } sq_state_e;
endpackage

// File: rtl/shram_cells.sv
// Working and shadow arrays, one pair per byte lane.
module shram_cells #(
   parameter int ADDR_W = 4,
   parameter int LANE_W = 8,
   parameter int LANES  = 2
) (
   input  logic                      clk,
   input  logic                      host_wr,
   input  logic [ADDR_W-1:0]         host_addr,
   input  logic [LANES*LANE_W-1:0]   host_wdata,
   input  logic [LANES-1:0]          lane_n,
   input  logic [ADDR_W-1:0]         xfer_idx,
   input  logic                      load_work,
   input  logic                      load_shadow,
   output logic [LANES*LANE_W-1:0]   host_word
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] work_m   [DEPTH];
      logic [LANE_W-1:0] shadow_m [DEPTH];

      always_ff @(posedge clk) begin
         if (load_work)
            work_m[xfer_idx] <= shadow_m[xfer_idx];
         else if (host_wr && !lane_n[l])
            work_m[host_addr] <= host_wdata[l*LANE_W +: LANE_W];
         if (load_shadow)
            shadow_m[xfer_idx] <= work_m[xfer_idx];
      end

      assign host_word[l*LANE_W +: LANE_W] = work_m[host_addr];
   end
endmodule

// File: rtl/shram_host.sv
// Host access qualification, registered read data and driver turn-off timer.
module shram_host #(
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   parameter int HZ_CYC = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs_n,
   input  logic                      oe_n,
   input  logic                      we_n,
   input  logic                      hw_req_n,
   input  logic [LANES-1:0]          lane_n,
   input  logic                      xfer_busy,
   input  logic [LANES*LANE_W-1:0]   word_in,
   output logic                      host_wr,
   output logic [LANES*LANE_W-1:0]   rdata,
   output logic [LANES-1:0]          dq_oe
);
   localparam int HZW = $clog2(HZ_CYC + 1);

   logic           access_ok;
   logic           host_rd;
   logic           keep_on;
   logic [HZW-1:0] wcnt;

   assign access_ok = hw_req_n && !xfer_busy && !cs_n;
   assign host_wr   = access_ok && !we_n;
   assign host_rd   = access_ok && !oe_n && we_n;
   assign keep_on   = access_ok && !oe_n && !we_n && (wcnt < HZW'(HZ_CYC));

   always_ff @(posedge clk) begin
      if (!rst_n)
         wcnt <= '0;
      else if (we_n || cs_n)
         wcnt <= '0;
      else if (wcnt != HZW'(HZ_CYC))
         wcnt <= wcnt + 1'b1;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic              oe_q;
      logic [LANE_W-1:0] rq;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            oe_q <= 1'b0;
            rq   <= '0;
         end else if (host_rd) begin
            oe_q <= !lane_n[l];
            rq   <= lane_n[l] ? '0 : word_in[l*LANE_W +: LANE_W];
         end else if (!keep_on) begin
            oe_q <= 1'b0;
         end
      end

      assign dq_oe[l] = oe_q;
      assign rdata[l*LANE_W +: LANE_W] = oe_q ? rq : '0;
   end
endmodule

// File: rtl/shram_trigger.sv
// Store/recall trigger arbitration, hardware delay timer and dirty tracking.
module shram_trigger #(
   parameter int DELAY_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_req_n,
   input  logic pwr_fail,
   input  logic auto_en,
   input  logic sw_store,
   input  logic sw_recall,
   input  logic seq_idle,
   input  logic host_wr,
   input  logic xfer_done,
   output logic store_go,
   output logic recall_go,
   output logic hold_go,
   output logic dirty_q
);
   localparam int CW = $clog2(DELAY_CYC + 1);

   logic          hw_prev;
   logic          pf_prev;
   logic          pend;
   logic [CW-1:0] cnt;
   logic          hw_fall;
   logic          hw_due;
   logic          armed;
   logic          pf_go;
   logic          hw_go;
   logic          sw_go;

   assign hw_fall   = hw_prev && !hw_req_n;
   assign hw_due    = pend && (cnt == '0);
   assign armed     = dirty_q || host_wr;
   assign pf_go     = seq_idle && pwr_fail && !pf_prev && auto_en && armed;
   assign hw_go     = seq_idle && hw_due && armed;
   assign sw_go     = seq_idle && sw_store;
   assign store_go  = sw_go || pf_go || hw_go;
   assign hold_go   = sw_go || (hw_go && !pf_go);
   assign recall_go = seq_idle && sw_recall && !store_go;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hw_prev <= 1'b1;
         pf_prev <= 1'b1;
         pend    <= 1'b0;
         cnt     <= '0;
         dirty_q <= 1'b0;
      end else begin
         hw_prev <= hw_req_n;
         pf_prev <= pwr_fail;
         if (hw_fall) begin
            pend <= 1'b1;
            cnt  <= CW'(DELAY_CYC - 1);
         end else if (pend) begin
            if (cnt != '0)
               cnt <= cnt - 1'b1;
            else if (seq_idle)
               pend <= 1'b0;
         end
         if (pf_go)
            pend <= 1'b0;
         if (xfer_done)
            dirty_q <= 1'b0;
         else if (host_wr)
            dirty_q <= 1'b1;
      end
   end
endmodule

// File: rtl/shram_seq.sv
// Bulk transfer sequencer: one word per clock, then an optional drive-high phase.
module shram_seq
   import shram_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int HOLD_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store_go,
   input  logic              recall_go,
   input  logic              hold_go,
   output logic [ADDR_W-1:0] xfer_idx,
   output logic              load_shadow,
   output logic              load_work,
   output logic              seq_idle,
   output logic              xfer_busy,
   output logic              xfer_done,
   output logic              busy_n,
   output logic              busy_drv
);
   localparam int HW = $clog2(HOLD_CYC + 1);

   sq_state_e     state;
   logic          hold_q;
   logic [HW-1:0] hcnt;

   assign xfer_busy   = (state == SQ_STORE) || (state == SQ_RECALL);
   assign xfer_done   = xfer_busy && (xfer_idx == '1);
   assign load_shadow = (state == SQ_STORE);
   assign load_work   = (state == SQ_RECALL);
   assign seq_idle    = (state == SQ_IDLE);
   assign busy_n      = !xfer_busy;
   assign busy_drv    = (state != SQ_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SQ_RECALL;
         xfer_idx <= '0;
         hold_q   <= 1'b0;
         hcnt     <= '0;
      end else begin
         unique case (state)
            SQ_IDLE: begin
               xfer_idx <= '0;
               if (store_go) begin
                  state  <= SQ_STORE;
                  hold_q <= hold_go;
               end else if (recall_go) begin
                  state  <= SQ_RECALL;
                  hold_q <= 1'b0;
               end
            end
            SQ_STORE, SQ_RECALL: begin
               xfer_idx <= xfer_idx + 1'b1;
               if (xfer_idx == '1) begin
                  if (hold_q) begin
                     state <= SQ_HOLD;
                     hcnt  <= HW'(HOLD_CYC - 1);
                  end else begin
                     state <= SQ_IDLE;
                  end
               end
            end
            SQ_HOLD: begin
               if (hcnt == '0)
                  state <= SQ_IDLE;
               else
                  hcnt <= hcnt - 1'b1;
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/shadow_ram_ctrl.sv
module shadow_ram_ctrl #(
   parameter int ADDR_W    = 4,
   parameter int LANE_W    = 8,
   parameter int LANES     = 2,
   parameter int DELAY_CYC = 4,
   parameter int HOLD_CYC  = 3,
   parameter int HZ_CYC    = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     oe_n,
   input  logic                     we_n,
   input  logic [LANES-1:0]         lane_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [LANES*LANE_W-1:0]  wdata,
   output logic [LANES*LANE_W-1:0]  rdata,
   output logic [LANES-1:0]         dq_oe,
   input  logic                     hw_req_n,
   output logic                     busy_n,
   output logic                     busy_drv,
   input  logic                     sw_store,
   input  logic                     sw_recall,
   input  logic                     pwr_fail,
   input  logic                     auto_en
);
   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("shadow_ram_ctrl: ADDR_W must be 1..10");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("shadow_ram_ctrl: LANES and LANE_W must be positive");
   end
   if (DELAY_CYC < 1 || HOLD_CYC < 1 || HZ_CYC < 1) begin : g_bad_timer
      $error("shadow_ram_ctrl: timer parameters must be at least 1");
   end

   logic              host_wr;
   logic              store_go;
   logic              recall_go;
   logic              hold_go;
   logic              dirty_q;
   logic              seq_idle;
   logic              xfer_busy;
   logic              xfer_done;
   logic              load_shadow;
   logic              load_work;
   logic [ADDR_W-1:0] xfer_idx;
   logic [DATA_W-1:0] host_word;

   shram_host #(.LANE_W(LANE_W), .LANES(LANES), .HZ_CYC(HZ_CYC)) u_host (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .hw_req_n(hw_req_n), .lane_n(lane_n), .xfer_busy(xfer_busy),
      .word_in(host_word), .host_wr(host_wr), .rdata(rdata), .dq_oe(dq_oe)
   );

   shram_trigger #(.DELAY_CYC(DELAY_CYC)) u_trig (
      .clk(clk), .rst_n(rst_n), .hw_req_n(hw_req_n), .pwr_fail(pwr_fail),
      .auto_en(auto_en), .sw_store(sw_store), .sw_recall(sw_recall),
      .seq_idle(seq_idle), .host_wr(host_wr), .xfer_done(xfer_done),
      .store_go(store_go), .recall_go(recall_go), .hold_go(hold_go),
      .dirty_q(dirty_q)
   );

   shram_seq #(.ADDR_W(ADDR_W), .HOLD_CYC(HOLD_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .store_go(store_go), .recall_go(recall_go),
      .hold_go(hold_go), .xfer_idx(xfer_idx), .load_shadow(load_shadow),
      .load_work(load_work), .seq_idle(seq_idle), .xfer_busy(xfer_busy),
      .xfer_done(xfer_done), .busy_n(busy_n), .busy_drv(busy_drv)
   );

   shram_cells #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_cells (
      .clk(clk), .host_wr(host_wr), .host_addr(addr), .host_wdata(wdata),
      .lane_n(lane_n), .xfer_idx(xfer_idx), .load_work(load_work),
      .load_shadow(load_shadow), .host_word(host_word)
   );
endmodule

// File: rtl/shadow_ram_ctrl_chk.sv
module shadow_ram_ctrl_chk #(
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             we_n,
   input logic             hw_req_n,
   input logic             sw_store,
   input logic             busy_n,
   input logic             busy_drv,
   input logic             seq_idle,
   input logic             dirty_q,
   input logic [LANES-1:0] dq_oe
);
   a_r3_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |=> (dq_oe == '0));

   a_r4_write_sets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !we_n && hw_req_n && busy_n) |=> dirty_q);

   a_r4_done_clears_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_n) |-> !dirty_q);

   a_r6_sw_store_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_idle && sw_store) |=> !busy_n);

   a_r8_busy_driven: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_n |-> busy_drv);
endmodule

bind shadow_ram_ctrl shadow_ram_ctrl_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/shadow_ram_ctrl_bench.sv
`timescale 1ns/1ps
module shadow_ram_ctrl_bench;
   localparam int AW    = 4;
   localparam int DEPTH = 1 << AW;
   localparam int DLY   = 4;
   localparam int HOLD  = 3;
   localparam int HZ    = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [1:0]  lane_n = 2'b11;
   logic [AW-1:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [1:0]  dq_oe;
   logic        hw_req_n = 1'b1;
   logic        busy_n, busy_drv;
   logic        sw_store = 1'b0, sw_recall = 1'b0, pwr_fail = 1'b0, auto_en = 1'b1;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [15:0] model [DEPTH];

   always #4 clk = ~clk;

   shadow_ram_ctrl #(.ADDR_W(AW), .LANE_W(8), .LANES(2), .DELAY_CYC(DLY),
                     .HOLD_CYC(HOLD), .HZ_CYC(HZ)) u_shadow_ram_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .lane_n(lane_n), .addr(addr), .wdata(wdata), .rdata(rdata), .dq_oe(dq_oe),
      .hw_req_n(hw_req_n), .busy_n(busy_n), .busy_drv(busy_drv),
      .sw_store(sw_store), .sw_recall(sw_recall), .pwr_fail(pwr_fail),
      .auto_en(auto_en)
   );

   function automatic logic [15:0] pat(input int i);
      return 16'((i * 16'h1357) ^ 16'hA5C3);
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic host_write(input logic [AW-1:0] a, input logic [15:0] d,
                             input logic [1:0] ln);
      cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d; lane_n = ln;
      @(negedge clk);
      cs_n = 1'b1; we_n = 1'b1; lane_n = 2'b11;
   endtask

   task automatic host_read(input logic [AW-1:0] a, input logic [1:0] ln,
                            output logic [15:0] d, output logic [1:0] o);
      cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a; lane_n = ln;
      @(negedge clk);
      d = rdata; o = dq_oe;
      cs_n = 1'b1; oe_n = 1'b1; lane_n = 2'b11;
   endtask

   task automatic meas(output int lo, output int hd);
      lo = 0; hd = 0;
      while (busy_n === 1'b0 && lo < 1000) begin lo++; @(negedge clk); end
      while (busy_n === 1'b1 && busy_drv === 1'b1 && hd < 1000) begin hd++; @(negedge clk); end
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 1000 && busy_drv !== 1'b0; k++) @(negedge clk);
   endtask

   task automatic quiet(input int n, input string tag);
      bit seen = 1'b0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (busy_n !== 1'b1) seen = 1'b1;
      end
      chk(!seen, tag, seen, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [15:0] d;
      logic [1:0]  o;
      int lo, hd, hi;

      repeat (3) @(negedge clk);
      chk(busy_n === 1'b0, "R11 busy low in reset", busy_n, 0);
      chk(dq_oe === 2'b00, "R1 dq_oe after reset", dq_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      meas(lo, hd);
      // release counts as edge 0; samples after edges 1..DEPTH-1 are low
      chk(lo == DEPTH - 1, "R11 power-up recall length", lo, DEPTH - 1);
      chk(hd == 0, "R9 no hold after recall", hd, 0);

      for (int i = 0; i < DEPTH; i++) begin
         host_write(AW'(i), pat(i), 2'b00);
         model[i] = pat(i);
      end
      for (int i = 0; i < DEPTH; i++) begin
         host_read(AW'(i), 2'b00, d, o);
         chk(d === model[i] && o === 2'b11, "R1 full-word readback", d, model[i]);
      end

      host_write(3, 16'hBEEF, 2'b10);
      model[3] = {model[3][15:8], 8'hEF};
      host_read(3, 2'b00, d, o);
      chk(d === model[3], "R2 low-lane write", d, model[3]);
      host_write(9, 16'h7700, 2'b01);
      model[9] = {8'h77, model[9][7:0]};
      host_read(9, 2'b01, d, o);
      chk(d === {model[9][15:8], 8'h00} && o === 2'b10, "R2 high-lane read",
          {o, d}, {2'b10, model[9][15:8], 8'h00});

      sw_store = 1'b1; @(negedge clk); sw_store = 1'b0;
      chk(busy_drv === 1'b1, "R8 busy driven", busy_drv, 1);
      meas(lo, hd);
      chk(lo == DEPTH, "R8 store length", lo, DEPTH);
      chk(hd == HOLD, "R9 hold after software store", hd, HOLD);

      // clean RAM: software store still runs, host blocked meanwhile
      sw_store = 1'b1; @(negedge clk); sw_store = 1'b0;
      chk(busy_n === 1'b0, "R6 clean software store runs", busy_n, 0);
      host_read(2, 2'b00, d, o);
      chk(o === 2'b00 && d === 16'h0, "R3 read refused while busy", {o, d}, 0);
      host_write(5, 16'h0000, 2'b00);
      wait_idle();
      host_read(5, 2'b00, d, o);
      chk(d === model[5], "R3 write discarded while busy", d, model[5]);

      for (int i = 0; i < DEPTH; i++) host_write(AW'(i), ~pat(i), 2'b00);
      sw_recall = 1'b1; @(negedge clk); sw_recall = 1'b0;
      meas(lo, hd);
      chk(lo == DEPTH && hd == 0, "R11 recall length, R9 no hold", {lo[15:0], hd[15:0]}, {16'(DEPTH), 16'h0});
      for (int i = 0; i < DEPTH; i++) begin
         host_read(AW'(i), 2'b00, d, o);
         chk(d === model[i], "R11 recall restores stored word", d, model[i]);
      end

      // recall cleared dirty: hardware and power-fail requests skipped
      hw_req_n = 1'b0; @(negedge clk); hw_req_n = 1'b1;
      quiet(DLY + 4, "R5 R4 clean hardware request skipped");
      pwr_fail = 1'b1;
      quiet(4, "R5 clean power-fail skipped");
      pwr_fail = 1'b0; @(negedge clk);

      host_write(0, 16'h1234, 2'b00); model[0] = 16'h1234;
      hw_req_n = 1'b0; @(negedge clk); hw_req_n = 1'b1;
      hi = 0;
      while (busy_n === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
      chk(hi == DLY, "R7 hardware delay", hi, DLY);
      meas(lo, hd);
      chk(lo == DEPTH && hd == HOLD, "R4 R9 dirty hardware store with hold",
          {lo[15:0], hd[15:0]}, {16'(DEPTH), 16'(HOLD)});

      host_write(1, 16'h5A5A, 2'b00); model[1] = 16'h5A5A;
      auto_en = 1'b0; pwr_fail = 1'b1;
      quiet(4, "R10 power-fail ignored when disabled");
      pwr_fail = 1'b0; @(negedge clk);
      auto_en = 1'b1; pwr_fail = 1'b1; @(negedge clk);
      chk(busy_n === 1'b0, "R10 power-fail store starts", busy_n, 0);
      meas(lo, hd);
      chk(lo == DEPTH && hd == 0, "R10 R9 power-fail store, no hold",
          {lo[15:0], hd[15:0]}, {16'(DEPTH), 16'h0});
      pwr_fail = 1'b0; @(negedge clk);

      // clean RAM; write lands at the edge where the delayed request matures
      hw_req_n = 1'b0; @(negedge clk); hw_req_n = 1'b1;
      repeat (DLY - 1) @(negedge clk);
      host_write(7, 16'hC0DE, 2'b00); model[7] = 16'hC0DE;
      chk(busy_n === 1'b0, "R5 same-edge write arms hardware store", busy_n, 0);
      wait_idle();

      host_write(2, 16'h2222, 2'b00); model[2] = 16'h2222;
      sw_store = 1'b1; pwr_fail = 1'b1; @(negedge clk);
      sw_store = 1'b0;
      meas(lo, hd);
      chk(lo == DEPTH && hd == HOLD, "R12 collapsed triggers, one store",
          {lo[15:0], hd[15:0]}, {16'(DEPTH), 16'(HOLD)});
      quiet(2 * DEPTH, "R12 no second store");
      pwr_fail = 1'b0; @(negedge clk);

      host_write(4, 16'h4444, 2'b00); model[4] = 16'h4444;
      hw_req_n = 1'b0; @(negedge clk);
      hw_req_n = 1'b1; pwr_fail = 1'b1; @(negedge clk);
      chk(busy_n === 1'b0, "R12 power-fail store preempts hardware", busy_n, 0);
      while (busy_n === 1'b0) @(negedge clk);
      host_write(6, 16'h6666, 2'b00); model[6] = 16'h6666;
      quiet(DEPTH, "R12 cancelled hardware request stays idle");
      pwr_fail = 1'b0; @(negedge clk);

      cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 8; lane_n = 2'b00;
      @(negedge clk);
      chk(dq_oe === 2'b11, "R13 drivers on before write", dq_oe, 2'b11);
      we_n = 1'b0; wdata = 16'h8888; model[8] = 16'h8888;
      hi = 0;
      for (int k = 0; k < HZ + 3; k++) begin
         @(negedge clk);
         if (dq_oe === 2'b11) hi++;
      end
      chk(hi == HZ, "R13 drivers off after write delay", hi, HZ);
      cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; lane_n = 2'b11;
      @(negedge clk);
      host_read(8, 2'b00, d, o);
      chk(d === model[8], "R13 R1 write with output enable held", d, model[8]);

      finish_run();
   end
endmodule